// File: doc/BRIEF.md
# Triple Serial-to-Parallel Latch

Three serial-in lanes share one shift clock, one storage clock, one active-low clear and one active-low output enable. On each rising shift-clock edge, every lane takes one serial bit into stage 0 and moves its other bits one stage along. The last stage of each lane drives a serial output, so further lanes or devices can be chained behind it.

A rising storage-clock edge copies each lane's whole shift chain into that lane's own holding register. The holding register feeds the parallel output. The clear input empties only the shift chains. The output enable only gates the parallel outputs. A global power-on reset puts both the shift chains and the holding registers into a defined zero state.

The parallel outputs are not a tri-state bus. They come out as a data bus plus an active-high drive-enable. A pad ring or a bus multiplexer outside the block can use that enable to control its own drivers.

Top module: `sipo_triple_latch`

## Requirements
- R1: On every rising edge of `sclk_i` with `sclr_ni` high, each lane k loads `sdata_i[k]` into stage 0, and stage n moves to stage n+1 for n from 0 to 6.
- R2: `sdata_o[k]` always equals stage 7 of lane k. After a shift, it therefore shows what stage 6 held before that edge.
- R3: On a rising edge of `pclk_i`, each lane's holding register takes all 8 shift stages at once. Parallel bit n of lane k is `pdata_o[k*8+n]` and shows stage n, where stage 0 is the newest bit.
- R4: When `sclk_i` and `pclk_i` rise together, the holding register receives the shift contents from before that shift. Storage therefore trails the shift chain by one edge.
- R5: While `sclr_ni` is low, all stages of all three shift chains are held at zero, at once and without any clock edge. The holding registers and `pdata_o` do not change.
- R6: While `sclr_ni` is low, every `sdata_o` bit reads 0. A `pclk_i` rise during the clear loads zeros into all holding registers.
- R7: With `oe_ni` high, `pdrive_o` is 0 and `pdata_o` is all zeros. With `oe_ni` low, `pdrive_o` is 1 and `pdata_o` shows the holding registers.
- R8: Changes on `oe_ni` never alter the holding registers. Turning the outputs back on shows the same data as before they were turned off.
- R9: While `rst_ni` is low, the shift chains and holding registers are zero. After release, `pdata_o` and `sdata_o` read zero until new data is shifted in and captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Global power-on reset, active low, asynchronous |
| sclk_i | input | 1 | Shift clock, rising edge active |
| pclk_i | input | 1 | Storage clock, rising edge active |
| sclr_ni | input | 1 | Shift-chain clear, active low, asynchronous |
| oe_ni | input | 1 | Parallel output enable, active low |
| sdata_i | input | 3 | Serial data in, bit k for lane k |
| sdata_o | output | 3 | Serial data out (stage 7), bit k for lane k |
| pdata_o | output | 24 | Parallel data, lane k at bits k*8+7 down to k*8 |
| pdrive_o | output | 1 | Output drive enable, high when outputs are driven |

## Verification
No pipeline sits between the clocks and the outputs. `sdata_o` changes in the same time step as a rising `sclk_i` edge (or a falling `sclr_ni` edge), and `pdata_o` changes in the same step as a rising `pclk_i` edge or any change on `oe_ni`. The bench raises the data clocks and changes the controls at the falling edge of its 125 MHz timebase. It updates a behavioural model of the three lanes at that same moment and compares every output half a period later, at the next rising timebase edge. This sampling point keeps every comparison clear of the data-clock edges. Clear release and rising shift edges are never placed in the same step, so the checks never depend on the order in which simultaneous events are processed.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  parameter int unsigned LANES_DEF = 3;
  parameter int unsigned WIDTH_DEF = 8;
endpackage

// File: rtl/sipo_shift_lane.sv
module sipo_shift_lane #(
  parameter int unsigned WIDTH = sipo_pkg::WIDTH_DEF
) (
  input  logic             sclk_i,
  input  logic             rst_ni,
  input  logic             sclr_ni,
  input  logic             sdata_i,
  output logic [WIDTH-1:0] stage_o,
  output logic             sdata_o
);
  logic             clr_n;
  logic [WIDTH-1:0] stage_q;

  // chain is emptied by either the power-on reset or the lane clear
  assign clr_n = rst_ni & sclr_ni;

  always_ff @(posedge sclk_i or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= {stage_q[WIDTH-2:0], sdata_i};
  end

  assign stage_o = stage_q;
  assign sdata_o = stage_q[WIDTH-1];

  // R5, R6
  assert_clear_R5: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !sclr_ni |-> (stage_q == '0 && !sdata_o))
    else $error("shift chain not empty under clear");
endmodule

// File: rtl/sipo_hold_lane.sv
module sipo_hold_lane #(
  parameter int unsigned WIDTH = sipo_pkg::WIDTH_DEF
) (
  input  logic             pclk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] shift_i,
  output logic [WIDTH-1:0] hold_o
);
  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= shift_i;
  end

  assign hold_o = hold_q;

  // R3, R4: value taken is the chain as sampled before the edge
  assert_capture_R3: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    1'b1 |=> (hold_q == $past(shift_i)))
    else $error("holding register missed chain contents");
endmodule

// File: rtl/sipo_out_drv.sv
module sipo_out_drv #(
  parameter int unsigned BUS = sipo_pkg::LANES_DEF * sipo_pkg::WIDTH_DEF
) (
  input  logic           oe_ni,
  input  logic [BUS-1:0] hold_i,
  output logic [BUS-1:0] data_o,
  output logic           drive_o
);
  always_comb begin
    drive_o = !oe_ni;
    data_o  = oe_ni ? '0 : hold_i;
  end
endmodule

// File: rtl/sipo_triple_latch.sv
module sipo_triple_latch #(
  parameter int unsigned LANES = sipo_pkg::LANES_DEF,
  parameter int unsigned WIDTH = sipo_pkg::WIDTH_DEF,
  localparam int unsigned BUS  = LANES * WIDTH
) (
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             pclk_i,
  input  logic             sclr_ni,
  input  logic             oe_ni,
  input  logic [LANES-1:0] sdata_i,
  output logic [LANES-1:0] sdata_o,
  output logic [BUS-1:0]   pdata_o,
  output logic             pdrive_o
);
  logic [BUS-1:0] shift_bus;
  logic [BUS-1:0] hold_bus;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sipo_shift_lane #(.WIDTH(WIDTH)) i_shift (
      .sclk_i  (sclk_i),
      .rst_ni  (rst_ni),
      .sclr_ni (sclr_ni),
      .sdata_i (sdata_i[g]),
      .stage_o (shift_bus[g*WIDTH +: WIDTH]),
      .sdata_o (sdata_o[g])
    );

    sipo_hold_lane #(.WIDTH(WIDTH)) i_hold (
      .pclk_i  (pclk_i),
      .rst_ni  (rst_ni),
      .shift_i (shift_bus[g*WIDTH +: WIDTH]),
      .hold_o  (hold_bus[g*WIDTH +: WIDTH])
    );
  end

  sipo_out_drv #(.BUS(BUS)) i_drv (
    .oe_ni   (oe_ni),
    .hold_i  (hold_bus),
    .data_o  (pdata_o),
    .drive_o (pdrive_o)
  );

  assert_hiz_R7: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    oe_ni |-> (!pdrive_o && pdata_o == '0))
    else $error("outputs driven while disabled");

  // R7, R8: enabled outputs track the holding registers
  assert_show_R7: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !oe_ni |-> (pdrive_o && pdata_o == hold_bus))
    else $error("enabled outputs differ from storage");
endmodule

// File: tb/test_sipo_triple_latch.sv
`timescale 1ns/1ps
module test_sipo_triple_latch;
  localparam int LANES = 3;
  localparam int WIDTH = 8;
  localparam int BUS   = LANES * WIDTH;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_ni  = 1'b0;
  logic             sclk    = 1'b0;
  logic             pclk    = 1'b0;
  logic             sclr_ni = 1'b1;
  logic             oe_ni   = 1'b0;
  logic [LANES-1:0] sdin    = '0;
  logic [LANES-1:0] sdout;
  logic [BUS-1:0]   pdata;
  logic             pdrive;

  sipo_triple_latch i_sipo_triple_latch (
    .rst_ni   (rst_ni),
    .sclk_i   (sclk),
    .pclk_i   (pclk),
    .sclr_ni  (sclr_ni),
    .oe_ni    (oe_ni),
    .sdata_i  (sdin),
    .sdata_o  (sdout),
    .pdata_o  (pdata),
    .pdrive_o (pdrive)
  );

  // behavioural model
  logic [WIDTH-1:0] m_sh [LANES];
  logic [WIDTH-1:0] m_st [LANES];
  logic             m_oe_n;
  string            tag = "R9";
  int               checks = 0;
  int               fails  = 0;
  bit               running = 0;
  bit               done = 0;

  function automatic logic [BUS-1:0] exp_pdata();
    logic [BUS-1:0] v = '0;
    if (!m_oe_n)
      for (int k = 0; k < LANES; k++) v[k*WIDTH +: WIDTH] = m_st[k];
    return v;
  endfunction

  function automatic logic [LANES-1:0] exp_sdout();
    logic [LANES-1:0] v;
    for (int k = 0; k < LANES; k++) v[k] = m_sh[k][WIDTH-1];
    return v;
  endfunction

  // one timebase cycle: controls and data-clock rises at the falling edge
  task automatic cyc(input bit s, input bit p, input logic [LANES-1:0] d,
                     input bit clr_n, input bit oe_n);
    @(negedge clk);
    sdin    = d;
    sclr_ni = clr_n;
    oe_ni   = oe_n;
    m_oe_n  = oe_n;
    if (!clr_n) for (int k = 0; k < LANES; k++) m_sh[k] = '0;
    if (p)      for (int k = 0; k < LANES; k++) m_st[k] = m_sh[k];
    if (s && clr_n)
      for (int k = 0; k < LANES; k++) m_sh[k] = {m_sh[k][WIDTH-2:0], d[k]};
    sclk = s;
    pclk = p;
    @(posedge clk);
    #1;
    sclk = 1'b0;
    pclk = 1'b0;
  endtask

  // shift three bytes in MSB first, optionally with pclk on every edge
  task automatic load(input logic [WIDTH-1:0] b0, input logic [WIDTH-1:0] b1,
                      input logic [WIDTH-1:0] b2, input bit with_p);
    for (int i = WIDTH - 1; i >= 0; i--)
      cyc(1'b1, with_p, {b2[i], b1[i], b0[i]}, 1'b1, m_oe_n);
  endtask

  always @(posedge clk) begin
    if (running && !done) begin
      checks++;
      if (sdout !== exp_sdout()) begin
        fails++;
        $display("FAIL %s sdata_o act=%b exp=%b", tag, sdout, exp_sdout());
      end
      checks++;
      if (pdata !== exp_pdata()) begin
        fails++;
        $display("FAIL %s pdata_o act=%h exp=%h", tag, pdata, exp_pdata());
      end
      checks++;
      if (pdrive !== !m_oe_n) begin
        fails++;
        $display("FAIL %s pdrive_o act=%b exp=%b", tag, pdrive, !m_oe_n);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < LANES; k++) begin m_sh[k] = '0; m_st[k] = '0; end
    m_oe_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni  = 1'b1;
    running = 1;
    // R9: zero state after reset
    tag = "R9";
    cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, '0, 1'b1, 1'b0);

    // R1, R2: shifting, serial outputs follow stage 7
    tag = "R1_R2";
    load(8'hA5, 8'h3C, 8'hF0, 1'b0);
    // R3: parallel transfer, bit n = stage n
    tag = "R3";
    cyc(1'b0, 1'b1, '0, 1'b1, 1'b0);
    tag = "R1_R2";
    load(8'h81, 8'h7E, 8'h19, 1'b0);
    tag = "R3";
    cyc(1'b0, 1'b1, '0, 1'b1, 1'b0);

    // R4: both clocks together, storage trails by one edge
    tag = "R4";
    load(8'h5A, 8'hC3, 8'h0F, 1'b1);
    cyc(1'b1, 1'b1, 3'b101, 1'b1, 1'b0);

    // R7: outputs off, then R8: storage intact after re-enable
    tag = "R7";
    cyc(1'b0, 1'b0, '0, 1'b1, 1'b1);
    cyc(1'b1, 1'b0, 3'b111, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, '0, 1'b1, 1'b1);
    tag = "R8";
    cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, '0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);

    // R5: clear empties chains, storage untouched
    tag = "R5";
    load(8'hFF, 8'hFF, 8'hFF, 1'b0);
    cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 3'b111, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
    // R6: pclk during clear loads zeros, serial outputs low
    tag = "R6";
    cyc(1'b0, 1'b1, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);
    tag = "R1_R2";
    load(8'h96, 8'h69, 8'hE7, 1'b0);
    tag = "R3";
    cyc(1'b0, 1'b1, '0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule